// File: doc/BRIEF.md
# Packed Ternary Dot-Product Engine

The engine computes 64-element dot products between a buffer of signed 8-bit activations and rows of ternary weights. Weights are held in byte-wide memory at five trits per byte and are decoded on the fly. Each decoded trit selects whether the matching activation is added, subtracted or skipped, so the datapath has no multiplier. The engine then clamps each row total into the signed 8-bit range and emits it as one result word.

A start pulse with a row count makes the engine walk through that many output rows in order. It reads one weight byte and one activation per cycle from two external memories, each with one cycle of read latency. Results come out one per row at a fixed spacing, and a done pulse closes the job. Loading weights and any post-processing of the results are left to the surrounding logic.

Top module: `tdot_engine`

## Requirements
- R1: For element k (0..63) of row r, the engine reads weight byte address 13*r + k/5 and activation address k. It uses base-3 digit number k%5 of that byte, counting the least significant digit as number 0. Digit 0 means weight 0, digit 1 means +1 and digit 2 means -1.
- R2: A weight byte from 243 to 255 decodes to five zero weights and contributes nothing to the row.
- R3: Digit number 4 of the thirteenth byte of each row (element 64) lies outside the row and has no effect on the result.
- R4: Each result equals the exact sum of weight times activation over the 64 elements, clamped to the range -128..127. No intermediate wrap occurs for totals up to ±8192.
- R5: Counting the clock edge that accepts start as edge 0, the result of row r is valid for exactly one cycle, from edge 65+64*r. Results come out in row order, and res_valid_o is never high outside a job.
- R6: The job covers min(row_count_i, 32) rows. A row count of 0 produces a done pulse one cycle after acceptance and no results.
- R7: done_o is a one-cycle pulse in the cycle after the last result. busy_o is high from acceptance until that cycle and low during it.
- R8: A start request while busy_o is high is ignored. The running job keeps its row count and timing, and no new job follows.
- R9: After reset, res_valid_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| row_count_i | input | 6 | Number of rows for the job (clamped to 32) |
| w_addr_o | output | 9 | Weight memory byte address |
| w_data_i | input | 8 | Weight byte, one cycle after address |
| act_addr_o | output | 6 | Activation buffer address |
| act_data_i | input | 8 | Signed activation, one cycle after address |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 8 | Saturated signed row result |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished pulse |

## Verification
The bench drives all-positive, all-negative and extreme-activation rows. With these, a design that wraps its accumulator or negates -128 in 8 bits produces a wrong sign instead of a clamped 127 or -128. It fills memory with bytes of 243 and above, which a design that decodes them literally would turn into nonzero weights. It also sets the unused fifth digit of each row's last byte, which catches a design that runs one element too far or packs rows without byte alignment. Zero and oversized row counts check the clamp and the empty job. A start pulse sent into a running job checks that the row count and the done timing stay unchanged.

// File: rtl/tdot_pkg.sv
package tdot_pkg;
  typedef enum logic [1:0] {
    TRIT_ZERO = 2'd0,
    TRIT_POS  = 2'd1,
    TRIT_NEG  = 2'd2
  } trit_e;
endpackage

// File: rtl/tdot_trit_decode.sv
module tdot_trit_decode #(
  parameter int PACK_W = 8,
  parameter int TRITS  = 5
) (
  input  logic [PACK_W-1:0]           byte_i,
  output tdot_pkg::trit_e [TRITS-1:0] trits_o
);
  localparam int LIMIT = 3 ** TRITS;
  localparam int QW    = PACK_W + 1;

  logic legal;
  assign legal = QW'(byte_i) < QW'(LIMIT);

  for (genvar j = 0; j < TRITS; j++) begin : g_digit
    localparam int POW = 3 ** j;
    logic [QW-1:0] quo;
    logic [QW-1:0] dig;
    assign quo = QW'(byte_i) / QW'(POW);
    assign dig = quo % QW'(3);
    assign trits_o[j] = legal ? tdot_pkg::trit_e'(dig[1:0]) : tdot_pkg::TRIT_ZERO;
  end
endmodule

// File: rtl/tdot_accum.sv
module tdot_accum #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic signed [ACT_W-1:0] act_i,
  input  tdot_pkg::trit_e         trit_i,
  output logic                    res_valid_o,
  output logic signed [ACT_W-1:0] res_data_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (ACT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] act_ext;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACT_W-1:0] clamped;

  assign act_ext = ACC_W'(act_i);

  always_comb begin
    case (trit_i)
      tdot_pkg::TRIT_POS: term = act_ext;
      tdot_pkg::TRIT_NEG: term = -act_ext;
      default:            term = '0;
    endcase
  end

  assign sum = first_i ? term : acc_q + term;

  always_comb begin
    if (sum > SAT_HI)      clamped = SAT_HI[ACT_W-1:0];
    else if (sum < SAT_LO) clamped = SAT_LO[ACT_W-1:0];
    else                   clamped = sum[ACT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= step_i & last_i;
      if (step_i) acc_q <= sum;
      if (step_i && last_i) res_data_o <= clamped;
    end
  end
endmodule

// File: rtl/tdot_seq.sv
module tdot_seq #(
  parameter int N_ELEM   = 64,
  parameter int TRITS    = 5,
  parameter int MAX_ROWS = 32,
  localparam int BYTES_PER_ROW = (N_ELEM + TRITS - 1) / TRITS,
  localparam int ELEM_W  = $clog2(N_ELEM),
  localparam int TRIT_W  = $clog2(TRITS),
  localparam int ROW_W   = $clog2(MAX_ROWS),
  localparam int CNT_W   = $clog2(MAX_ROWS + 1),
  localparam int WADDR_W = $clog2(MAX_ROWS * BYTES_PER_ROW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   row_count_i,
  output logic [WADDR_W-1:0] w_addr_o,
  output logic [ELEM_W-1:0]  act_addr_o,
  output logic [TRIT_W-1:0]  trit_sel_o,
  output logic               step_o,
  output logic               first_o,
  output logic               last_o,
  output logic               busy_o,
  output logic               done_o
);
  logic               busy_q, issue_q;
  logic [ELEM_W-1:0]  elem_q;
  logic [TRIT_W-1:0]  trit_q;
  logic [WADDR_W-1:0] byte_q, base_q;
  logic [ROW_W-1:0]   row_q, rows_m1_q;
  logic               fin_q, fin2_q;
  logic [CNT_W-1:0]   cnt_clamp;
  logic               accept, elem_last, row_last;

  assign cnt_clamp = (row_count_i > CNT_W'(MAX_ROWS)) ? CNT_W'(MAX_ROWS) : row_count_i;
  assign accept    = start_i & ~busy_q;
  assign elem_last = elem_q == ELEM_W'(N_ELEM - 1);
  assign row_last  = row_q == rows_m1_q;

  assign w_addr_o   = base_q + byte_q;
  assign act_addr_o = elem_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      issue_q    <= 1'b0;
      elem_q     <= '0;
      trit_q     <= '0;
      byte_q     <= '0;
      base_q     <= '0;
      row_q      <= '0;
      rows_m1_q  <= '0;
      step_o     <= 1'b0;
      first_o    <= 1'b0;
      last_o     <= 1'b0;
      trit_sel_o <= '0;
      fin_q      <= 1'b0;
      fin2_q     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      fin2_q <= step_o & fin_q;
      done_o <= fin2_q;
      if (fin2_q) busy_q <= 1'b0;

      if (accept) begin
        if (cnt_clamp == '0) begin
          done_o <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          issue_q   <= 1'b1;
          elem_q    <= '0;
          trit_q    <= '0;
          byte_q    <= '0;
          base_q    <= '0;
          row_q     <= '0;
          rows_m1_q <= ROW_W'(cnt_clamp - CNT_W'(1));
        end
      end

      step_o <= issue_q;
      fin_q  <= issue_q & elem_last & row_last;
      if (issue_q) begin
        trit_sel_o <= trit_q;
        first_o    <= elem_q == '0;
        last_o     <= elem_last;
        if (elem_last) begin
          elem_q <= '0;
          trit_q <= '0;
          byte_q <= '0;
          base_q <= base_q + WADDR_W'(BYTES_PER_ROW);
          row_q  <= row_q + ROW_W'(1);
          if (row_last) issue_q <= 1'b0;
        end else begin
          elem_q <= elem_q + ELEM_W'(1);
          if (trit_q == TRIT_W'(TRITS - 1)) begin
            trit_q <= '0;
            byte_q <= byte_q + WADDR_W'(1);
          end else begin
            trit_q <= trit_q + TRIT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdot_engine.sv
module tdot_engine #(
  parameter int N_ELEM   = 64,
  parameter int TRITS    = 5,
  parameter int MAX_ROWS = 32,
  parameter int PACK_W   = 8,
  parameter int ACT_W    = 8,
  parameter int ACC_W    = 16
) (
  input  logic                                                clk_i,
  input  logic                                                rst_ni,
  input  logic                                                start_i,
  input  logic [$clog2(MAX_ROWS+1)-1:0]                       row_count_i,
  output logic [$clog2(MAX_ROWS*((N_ELEM+TRITS-1)/TRITS))-1:0] w_addr_o,
  input  logic [PACK_W-1:0]                                   w_data_i,
  output logic [$clog2(N_ELEM)-1:0]                           act_addr_o,
  input  logic signed [ACT_W-1:0]                             act_data_i,
  output logic                                                res_valid_o,
  output logic signed [ACT_W-1:0]                             res_data_o,
  output logic                                                busy_o,
  output logic                                                done_o
);
  localparam int TRIT_W = $clog2(TRITS);

  logic [TRIT_W-1:0]           trit_sel;
  logic                        step, first, last;
  tdot_pkg::trit_e [TRITS-1:0] trits;
  tdot_pkg::trit_e             trit_cur;

  tdot_seq #(
    .N_ELEM  (N_ELEM),
    .TRITS   (TRITS),
    .MAX_ROWS(MAX_ROWS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .row_count_i(row_count_i),
    .w_addr_o   (w_addr_o),
    .act_addr_o (act_addr_o),
    .trit_sel_o (trit_sel),
    .step_o     (step),
    .first_o    (first),
    .last_o     (last),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  tdot_trit_decode #(
    .PACK_W(PACK_W),
    .TRITS (TRITS)
  ) u_dec (
    .byte_i (w_data_i),
    .trits_o(trits)
  );

  assign trit_cur = trits[trit_sel];

  tdot_accum #(
    .ACT_W(ACT_W),
    .ACC_W(ACC_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .first_i    (first),
    .last_i     (last),
    .act_i      (act_data_i),
    .trit_i     (trit_cur),
    .res_valid_o(res_valid_o),
    .res_data_o (res_data_o)
  );
endmodule

// File: rtl/tdot_engine_chk.sv
module tdot_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic res_valid_o,
  input logic busy_o,
  input logic done_o
);
  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_valid_in_job_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_ends_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o || done_o));

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_done_after_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> $past(res_valid_o));
endmodule

bind tdot_engine tdot_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .res_valid_o(res_valid_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tdot_engine_bench.sv
module tdot_engine_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [5:0]        row_count = '0;
  logic [8:0]        w_addr;
  logic [7:0]        w_data;
  logic [5:0]        act_addr;
  logic signed [7:0] act_data;
  logic              res_valid;
  logic signed [7:0] res_data;
  logic              busy, done;

  logic [7:0]        wmem [0:415];
  logic signed [7:0] amem [0:63];
  int n_chk = 0, n_fail = 0;
  int exp_res [0:31];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdot_engine u_tdot_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .row_count_i(row_count),
    .w_addr_o(w_addr), .w_data_i(w_data), .act_addr_o(act_addr),
    .act_data_i(act_data), .res_valid_o(res_valid), .res_data_o(res_data),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    w_data   <= (w_addr < 9'd416) ? wmem[w_addr] : 8'd0;
    act_data <= amem[act_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ref_row(input int r);
    int s = 0;
    for (int k = 0; k < 64; k++) begin
      int b = wmem[r * 13 + k / 5];
      int w = 0;
      if (b < 243) begin
        int p = 1;
        int d;
        for (int i = 0; i < k % 5; i++) p = p * 3;
        d = (b / p) % 3;
        w = (d == 1) ? 1 : ((d == 2) ? -1 : 0);
      end
      s += w * int'(amem[k]);
    end
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return s;
  endfunction

  // wmode 0: legal random, 1: constant, 2: any byte random
  task automatic fill_w(input int mode, input int val);
    for (int i = 0; i < 416; i++)
      wmem[i] = (mode == 0) ? 8'($urandom_range(0, 242)) :
                (mode == 1) ? 8'(val) : 8'($urandom_range(0, 255));
  endtask

  // amode 0: random in [-val,val], 1: constant
  task automatic fill_a(input int mode, input int val);
    for (int i = 0; i < 64; i++)
      amem[i] = (mode == 1) ? 8'(val) : 8'($urandom_range(0, 2 * val) - val);
  endtask

  task automatic run_job(input int cnt, input int ignore_at, input string dtag, input string ftag);
    int rows = (cnt > 32) ? 32 : cnt;
    int done_j = (rows == 0) ? 1 : 67 + 64 * (rows - 1);
    for (int r = 0; r < rows; r++) exp_res[r] = ref_row(r);
    @(negedge clk);
    start = 1'b1;
    row_count = 6'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= done_j + 3; j++) begin
      bit ev = (rows > 0) && (j >= 66) && ((j - 66) % 64 == 0) && ((j - 66) / 64 < rows);
      if (j == ignore_at) begin
        start = 1'b1;
        row_count = 6'd5;
      end else if (j == ignore_at + 1) begin
        start = 1'b0;
      end
      chk(res_valid == ev, {ftag, " R5 valid"}, res_valid, ev);
      if (ev && res_valid)
        chk(int'(res_data) == exp_res[(j - 66) / 64], {dtag, " data"}, res_data, exp_res[(j - 66) / 64]);
      chk(done == (j == done_j), {ftag, " R7 done"}, done, j == done_j);
      chk(busy == (rows > 0 && j < done_j), {ftag, " R7 busy"}, busy, rows > 0 && j < done_j);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid && !done && !busy, "R9 reset", {res_valid, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && !done && !busy, "R9 after reset", {res_valid, done, busy}, 0);

    // R1: random legal weights, three rows on byte-aligned bases
    fill_w(0, 0); fill_a(0, 20);
    run_job(3, 0, "R1", "R1");
    // R4: exact unsaturated sums
    fill_w(0, 0); fill_a(0, 3);
    run_job(2, 0, "R4 exact", "R4");
    // R4: saturation corners
    fill_w(1, 121); fill_a(1, 127);
    run_job(1, 0, "R4 pos sat", "R4");
    fill_w(1, 242); fill_a(1, -128);
    run_job(1, 0, "R4 neg*neg", "R4");
    fill_w(1, 121); fill_a(1, -128);
    run_job(1, 0, "R4 neg sat", "R4");
    // R2: illegal bytes
    fill_w(2, 0); fill_a(0, 100);
    run_job(4, 0, "R2 mixed", "R2");
    fill_w(1, 250); fill_a(1, 90);
    run_job(1, 0, "R2 all illegal", "R2");
    // R3: fifth digit of each row's last byte set to -1
    fill_w(0, 0); fill_a(0, 30);
    for (int r = 0; r < 32; r++) wmem[r * 13 + 12] = 8'(162 + $urandom_range(0, 80));
    amem[0] = 8'sd100;
    run_job(2, 0, "R3", "R3");
    // R6: empty job and oversized count
    run_job(0, 0, "R6", "R6");
    fill_w(0, 0); fill_a(0, 40);
    run_job(40, 0, "R6 clamp", "R6");
    // R8: start pulses during a busy job
    fill_w(0, 0); fill_a(0, 25);
    run_job(2, 10, "R8", "R8");
    run_job(2, 129, "R8 late", "R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule